// File: doc/BRIEF.md
# Multi-Block Transfer Sequencer

This block is the control engine of one DMA channel. It counts the data items that the datapath reports as moved, checks the count against a programmed block length, and at every block boundary decides whether the transfer stops, waits for software, or moves on to the next block. It tells the source and destination address generators when to go back to their start values (reload) or to take new values from a list item (load). It also keeps three sticky interrupt flags: block complete, transfer complete and error.

There are three ways a transfer can run. With no reload and no list bits set, the channel runs one block and stops. With a reload bit set, each block ends with a reload strobe. If the block interrupt is enabled, the channel then waits until software clears that flag. Clearing the reload bits while a block is running makes that block the last one. With a list bit set, the next-pointer input stands in for the fetched list item. A non-zero pointer loads the side that has its list bit set and the next block starts at once. A zero pointer ends the transfer. The datapath can also be the flow controller. In that case a block ends on an item strobe flagged as last, and the programmed length is not used.

Top module: `mblk_seq`

## Requirements
- R1: After reset the channel is idle: `ch_active_o`=0, `ch_inactive_o`=1, `item_req_o`=0, and all reload, load and interrupt outputs are 0.
- R2: A `start_i` pulse on an idle channel makes `ch_active_o` and `item_req_o` high after the next clock edge, provided the configuration is legal and the channel is not suspended.
- R3: With DMA flow control and no reload or list bits, the channel goes idle on the edge that registers item number `cfg_block_ts_i`. On that same edge it sets the block flag and the transfer flag, and not on any earlier item.
- R4: With a reload bit set, no list bit set, and the block interrupt enabled, the edge that ends a block gives a one-cycle pulse on `src_reload_o` and/or `dst_reload_o`, one for each reload bit that is set. The channel then stays active with `item_req_o`=0 until a clear pulse on the block flag. After that clear it requests items again, and the item count starts again from zero.
- R5: In reload mode with the block interrupt disabled, the next block starts without a pause (`item_req_o` stays 1).
- R6: With a list bit set and a non-zero `next_ptr_i` at the block end, the channel sets the block flag and pulses `src_load_o`/`dst_load_o` for each side whose list bit is set. It pulses the reload output of a side that has reload set and no list bit. It keeps requesting items without waiting, even when the block interrupt is enabled.
- R7: In list mode, a zero `next_ptr_i` at the block end makes the channel go idle and set the transfer flag.
- R8: If the reload bits are cleared while a block is running, that block is the last: the channel goes idle and sets the transfer flag.
- R9: With peripheral flow control (`cfg_dmac_fc_i`=0), a block ends only on an item strobe that has `item_last_i`=1. The block length is ignored, and a zero length is not an error.
- R10: A start with DMA flow control and `cfg_block_ts_i`=0 sets the error flag, and the channel stays idle.
- R11: An item strobe while the channel is idle or waiting in reload mode sets the error flag.
- R12: Each flag (bit 0 block, bit 1 transfer, bit 2 error in `irq_en_i` and `irq_clr_i`) is set only when its enable bit is 1. It stays set until a clear pulse on its own bit, and clearing one flag leaves the other flags unchanged.
- R13: While `suspend_i`=1, `item_req_o` is 0. Item strobes already in flight are still counted. `ch_inactive_o` is 1 when the channel is idle, or when it is suspended with `item_busy_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Channel enable pulse |
| cfg_dmac_fc_i | input | 1 | 1: block length counted by the sequencer; 0: the datapath marks the last item |
| cfg_block_ts_i | input | CNT_W (12) | Items per block |
| cfg_reload_src_i | input | 1 | Return the source address to its start value at each block end |
| cfg_reload_dst_i | input | 1 | Return the destination address to its start value at each block end |
| cfg_list_src_i | input | 1 | Source address comes from a list item |
| cfg_list_dst_i | input | 1 | Destination address comes from a list item |
| next_ptr_i | input | PTR_W (32) | Next-item pointer of the current list item; zero means end |
| suspend_i | input | 1 | Hold off new item requests |
| irq_en_i | input | 3 | Flag enables: bit 0 block, bit 1 transfer, bit 2 error |
| irq_clr_i | input | 3 | Write-one-to-clear pulses, same bit order |
| item_done_i | input | 1 | One item moved by the datapath |
| item_last_i | input | 1 | Qualifies item_done_i as the last item under peripheral flow control |
| item_busy_i | input | 1 | Datapath holds an item in flight |
| ch_active_o | output | 1 | Transfer in progress |
| ch_inactive_o | output | 1 | Safe to pause or abort |
| item_req_o | output | 1 | Channel asks the datapath for items |
| src_reload_o | output | 1 | Pulse: reload source address |
| dst_reload_o | output | 1 | Pulse: reload destination address |
| src_load_o | output | 1 | Pulse: load source address from the list item |
| dst_load_o | output | 1 | Pulse: load destination address from the list item |
| blk_irq_o | output | 1 | Block-complete flag |
| xfer_irq_o | output | 1 | Transfer-complete flag |
| err_irq_o | output | 1 | Error flag |

## Verification
The item counter and the control state are internal. The bench therefore finds faults through their effect on timing at the ports. A wrong item count shows up as the block boundary arriving early or late: the idle state, a reload or load strobe, or the flags change on the wrong item edge. This is visible in the first cycle after that edge. The bench sweeps block lengths and list lengths, so an off-by-one moves the edge it checks. A wrong decision at the boundary shows up at once: the wait state is entered or skipped, so `item_req_o` drops or stays high, or the wrong strobe fires. A flag whose set or clear logic is wrong is caught on the cycle after the clear pulse, or a few idle cycles later for the sticky behaviour.

// File: rtl/mblk_pkg.sv
package mblk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_st_e;

    localparam int N_IRQ    = 3;
    localparam int IRQ_BLK  = 0;
    localparam int IRQ_XFER = 1;
    localparam int IRQ_ERR  = 2;

endpackage

// File: rtl/mblk_cnt.sv
module mblk_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.cnt = '0;
        end else if (inc_i) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // The item being strobed now is the final one of the block.
    assign last_o = ({1'b0, c_q.cnt} + EXT_W'(1)) == {1'b0, limit_i};

    // R3: each counted item advances the count by exactly one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (c_q.cnt == $past(c_q.cnt) + 1'b1));

    p_count_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (c_q.cnt == '0));

endmodule

// File: rtl/mblk_irq.sv
module mblk_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } irq_s;

    irq_s f_d, f_q;

    // A set in the same cycle as a clear wins, so no event is lost.
    always_comb begin
        f_d      = f_q;
        f_d.flag = (f_q.flag & ~clr_i) | (set_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_o = f_q.flag;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R12: a flag holds until its own clear pulse
        p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (f_q.flag[i] && !clr_i[i]) |=> f_q.flag[i]);
        // R12: a clear without a new event empties the flag
        p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !(set_i[i] && en_i[i])) |=> !f_q.flag[i]);
        // R12: a disabled type never rises
        p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!f_q.flag[i] && !en_i[i]) |=> !f_q.flag[i]);
    end

endmodule

// File: rtl/mblk_fsm.sv
module mblk_fsm
    import mblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dmac_fc_i,
    input  logic             ts_zero_i,
    input  logic             reload_src_i,
    input  logic             reload_dst_i,
    input  logic             list_src_i,
    input  logic             list_dst_i,
    input  logic             next_null_i,
    input  logic             suspend_i,
    input  logic             blk_en_i,
    input  logic             blk_clr_i,
    input  logic             item_done_i,
    input  logic             item_last_i,
    input  logic             cnt_last_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic [N_IRQ-1:0] irq_set_o,
    output logic             active_o,
    output logic             item_req_o,
    output logic             src_reload_o,
    output logic             dst_reload_o,
    output logic             src_load_o,
    output logic             dst_load_o
);
    typedef struct packed {
        seq_st_e st;
        logic    src_rl;
        logic    dst_rl;
        logic    src_ld;
        logic    dst_ld;
    } fsm_s;

    fsm_s s_d, s_q;

    logic list_any, reload_any, blk_end;

    assign list_any   = list_src_i | list_dst_i;
    assign reload_any = reload_src_i | reload_dst_i;
    assign blk_end    = item_done_i & (dmac_fc_i ? cnt_last_i : item_last_i);

    always_comb begin
        s_d        = s_q;
        s_d.src_rl = 1'b0;
        s_d.dst_rl = 1'b0;
        s_d.src_ld = 1'b0;
        s_d.dst_ld = 1'b0;
        cnt_clr_o  = 1'b0;
        cnt_inc_o  = 1'b0;
        irq_set_o  = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (item_done_i) begin
                    irq_set_o[IRQ_ERR] = 1'b1;
                end
                if (start_i) begin
                    if (dmac_fc_i && ts_zero_i) begin
                        irq_set_o[IRQ_ERR] = 1'b1;
                    end else begin
                        s_d.st    = ST_RUN;
                        cnt_clr_o = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (item_done_i) begin
                    cnt_inc_o = 1'b1;
                end
                if (blk_end) begin
                    cnt_clr_o          = 1'b1;
                    irq_set_o[IRQ_BLK] = 1'b1;
                    if (list_any) begin
                        if (next_null_i) begin
                            irq_set_o[IRQ_XFER] = 1'b1;
                            s_d.st              = ST_IDLE;
                        end else begin
                            s_d.src_ld = list_src_i;
                            s_d.dst_ld = list_dst_i;
                            s_d.src_rl = reload_src_i & ~list_src_i;
                            s_d.dst_rl = reload_dst_i & ~list_dst_i;
                        end
                    end else if (reload_any) begin
                        s_d.src_rl = reload_src_i;
                        s_d.dst_rl = reload_dst_i;
                        if (blk_en_i) begin
                            s_d.st = ST_HOLD;
                        end
                    end else begin
                        irq_set_o[IRQ_XFER] = 1'b1;
                        s_d.st              = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (item_done_i) begin
                    irq_set_o[IRQ_ERR] = 1'b1;
                end
                if (blk_clr_i) begin
                    s_d.st = ST_RUN;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o     = (s_q.st != ST_IDLE);
    assign item_req_o   = (s_q.st == ST_RUN) && !suspend_i;
    assign src_reload_o = s_q.src_rl;
    assign dst_reload_o = s_q.dst_rl;
    assign src_load_o   = s_q.src_ld;
    assign dst_load_o   = s_q.dst_ld;

    // R10: an illegal start leaves the channel idle
    p_zero_ts_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && start_i && dmac_fc_i && ts_zero_i) |=> (s_q.st == ST_IDLE));

    // R4: the wait state is left only through a block-flag clear
    p_hold_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HOLD && !blk_clr_i) |=> (s_q.st == ST_HOLD));

    // R6: list loads never come with the wait state
    p_load_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.src_ld || s_q.dst_ld) |-> (s_q.st == ST_RUN));

endmodule

// File: rtl/mblk_seq.sv
module mblk_seq
    import mblk_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cfg_dmac_fc_i,
    input  logic [CNT_W-1:0] cfg_block_ts_i,
    input  logic             cfg_reload_src_i,
    input  logic             cfg_reload_dst_i,
    input  logic             cfg_list_src_i,
    input  logic             cfg_list_dst_i,
    input  logic [PTR_W-1:0] next_ptr_i,
    input  logic             suspend_i,
    input  logic [2:0]       irq_en_i,
    input  logic [2:0]       irq_clr_i,
    input  logic             item_done_i,
    input  logic             item_last_i,
    input  logic             item_busy_i,
    output logic             ch_active_o,
    output logic             ch_inactive_o,
    output logic             item_req_o,
    output logic             src_reload_o,
    output logic             dst_reload_o,
    output logic             src_load_o,
    output logic             dst_load_o,
    output logic             blk_irq_o,
    output logic             xfer_irq_o,
    output logic             err_irq_o
);
    logic             cnt_clr, cnt_inc, cnt_last;
    logic [N_IRQ-1:0] irq_set, irq_flag;
    logic             ts_zero, next_null;

    assign ts_zero   = (cfg_block_ts_i == '0);
    assign next_null = (next_ptr_i == '0);

    mblk_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .limit_i (cfg_block_ts_i),
        .last_o  (cnt_last)
    );

    mblk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dmac_fc_i    (cfg_dmac_fc_i),
        .ts_zero_i    (ts_zero),
        .reload_src_i (cfg_reload_src_i),
        .reload_dst_i (cfg_reload_dst_i),
        .list_src_i   (cfg_list_src_i),
        .list_dst_i   (cfg_list_dst_i),
        .next_null_i  (next_null),
        .suspend_i    (suspend_i),
        .blk_en_i     (irq_en_i[IRQ_BLK]),
        .blk_clr_i    (irq_clr_i[IRQ_BLK]),
        .item_done_i  (item_done_i),
        .item_last_i  (item_last_i),
        .cnt_last_i   (cnt_last),
        .cnt_clr_o    (cnt_clr),
        .cnt_inc_o    (cnt_inc),
        .irq_set_o    (irq_set),
        .active_o     (ch_active_o),
        .item_req_o   (item_req_o),
        .src_reload_o (src_reload_o),
        .dst_reload_o (dst_reload_o),
        .src_load_o   (src_load_o),
        .dst_load_o   (dst_load_o)
    );

    mblk_irq #(.N(N_IRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .en_i   (irq_en_i),
        .clr_i  (irq_clr_i),
        .flag_o (irq_flag)
    );

    assign blk_irq_o     = irq_flag[IRQ_BLK];
    assign xfer_irq_o    = irq_flag[IRQ_XFER];
    assign err_irq_o     = irq_flag[IRQ_ERR];
    assign ch_inactive_o = !ch_active_o || (suspend_i && !item_busy_i);

    // R4: a reload strobe follows an item strobe
    p_reload_after_item_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reload_o || dst_reload_o) |-> $past(item_done_i));

    // R7: transfer completion coincides with the channel going idle
    p_xfer_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_irq_o) |-> !ch_active_o);

    // R6: a list load leaves the channel running
    p_load_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_load_o || dst_load_o) |-> ch_active_o);

    // R13: no item request while suspended
    p_susp_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |-> !item_req_o);

endmodule

// File: tb/mblk_seq_tb.sv
module mblk_seq_tb;
    localparam int CNT_W = 12;
    localparam int PTR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, cfg_dmac_fc_i = 1;
    logic [CNT_W-1:0] cfg_block_ts_i = '0;
    logic cfg_reload_src_i = 0, cfg_reload_dst_i = 0, cfg_list_src_i = 0, cfg_list_dst_i = 0;
    logic [PTR_W-1:0] next_ptr_i = '0;
    logic suspend_i = 0;
    logic [2:0] irq_en_i = 3'b111, irq_clr_i = 3'b000;
    logic item_done_i = 0, item_last_i = 0, item_busy_i = 0;
    logic ch_active_o, ch_inactive_o, item_req_o;
    logic src_reload_o, dst_reload_o, src_load_o, dst_load_o;
    logic blk_irq_o, xfer_irq_o, err_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mblk_seq #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_dut (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
    endtask

    task automatic items(int n, logic last);
        for (int i = 0; i < n; i++) begin
            item_done_i = 1'b1;
            item_last_i = last;
            cyc();
        end
        item_done_i = 1'b0;
        item_last_i = 1'b0;
    endtask

    task automatic clr(logic [2:0] m);
        irq_clr_i = m;
        cyc();
        irq_clr_i = 3'b000;
    endtask

    task automatic mode(logic rs, logic rd, logic ls, logic ld);
        cfg_reload_src_i = rs;
        cfg_reload_dst_i = rd;
        cfg_list_src_i   = ls;
        cfg_list_dst_i   = ld;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1", "active", ch_active_o, 0);
        chk("R1", "inactive", ch_inactive_o, 1);
        chk("R1", "req", item_req_o, 0);
        chk("R1", "strobes", {src_reload_o, dst_reload_o, src_load_o, dst_load_o}, 0);
        chk("R1", "flags", {blk_irq_o, xfer_irq_o, err_irq_o}, 0);
        rst_n = 1'b1;
        cyc();

        // R3 single block, sweep of lengths
        for (int ts = 1; ts <= 10; ts++) begin
            cfg_block_ts_i = CNT_W'(ts);
            mode(0, 0, 0, 0);
            pulse_start();
            chk("R2", "active after start", ch_active_o, 1);
            chk("R2", "req after start", item_req_o, 1);
            if (ts > 1) begin
                items(ts - 1, 0);
                chk("R3", "active before last item", ch_active_o, 1);
                chk("R3", "no early xfer", xfer_irq_o, 0);
            end
            items(1, 0);
            chk("R3", "idle at block end", ch_active_o, 0);
            chk("R3", "blk flag", blk_irq_o, 1);
            chk("R3", "xfer flag", xfer_irq_o, 1);
            chk("R3", "no err", err_irq_o, 0);
            clr(3'b111);
            chk("R12", "all cleared", {blk_irq_o, xfer_irq_o, err_irq_o}, 0);
        end

        // R4 reload source with block interrupt enabled, then R8 and R11
        cfg_block_ts_i = 3;
        mode(1, 0, 0, 0);
        pulse_start();
        items(3, 0);
        chk("R4", "src reload pulse", src_reload_o, 1);
        chk("R4", "no dst reload", dst_reload_o, 0);
        chk("R4", "still active", ch_active_o, 1);
        chk("R4", "paused", item_req_o, 0);
        chk("R4", "blk flag", blk_irq_o, 1);
        chk("R4", "no xfer", xfer_irq_o, 0);
        cyc();
        chk("R4", "pulse one cycle", src_reload_o, 0);
        repeat (3) cyc();
        chk("R4", "still paused", item_req_o, 0);
        items(1, 0);
        chk("R11", "item during wait", err_irq_o, 1);
        chk("R11", "wait kept", item_req_o, 0);
        clr(3'b101);
        chk("R4", "resumed", item_req_o, 1);
        chk("R4", "blk cleared", blk_irq_o, 0);
        mode(0, 0, 0, 0);
        items(2, 0);
        chk("R8", "count restarted", ch_active_o, 1);
        items(1, 0);
        chk("R8", "final block ends", ch_active_o, 0);
        chk("R8", "xfer flag", xfer_irq_o, 1);
        chk("R8", "no reload on last", src_reload_o, 0);
        clr(3'b111);

        // R5 reload destination, block interrupt disabled
        irq_en_i = 3'b110;
        cfg_block_ts_i = 4;
        mode(0, 1, 0, 0);
        pulse_start();
        for (int b = 0; b < 3; b++) begin
            items(4, 0);
            chk("R5", "dst reload", dst_reload_o, 1);
            chk("R5", "no pause", item_req_o, 1);
            chk("R5", "blk masked", blk_irq_o, 0);
        end
        mode(0, 0, 0, 0);
        items(4, 0);
        chk("R8", "ends after reload cleared", ch_active_o, 0);
        chk("R8", "xfer flag", xfer_irq_o, 1);
        clr(3'b111);
        irq_en_i = 3'b111;

        // R6/R7 list chains of several lengths
        cfg_block_ts_i = 2;
        for (int len = 1; len <= 4; len++) begin
            mode(0, 0, 1, 1);
            pulse_start();
            for (int b = 0; b < len; b++) begin
                next_ptr_i = (b == len - 1) ? 32'h0 : 32'h100 * (b + 1);
                items(2, 0);
                if (b < len - 1) begin
                    chk("R6", "src load", src_load_o, 1);
                    chk("R6", "dst load", dst_load_o, 1);
                    chk("R6", "keeps running", item_req_o, 1);
                    chk("R6", "blk flag", blk_irq_o, 1);
                    clr(3'b001);
                end else begin
                    chk("R7", "idle at null", ch_active_o, 0);
                    chk("R7", "xfer flag", xfer_irq_o, 1);
                    chk("R7", "no load", {src_load_o, dst_load_o}, 0);
                end
            end
            clr(3'b111);
        end

        // R6 mixed: source list, destination reload
        mode(0, 1, 1, 0);
        pulse_start();
        next_ptr_i = 32'h40;
        items(2, 0);
        chk("R6", "mixed strobes", {src_reload_o, dst_reload_o, src_load_o, dst_load_o}, 4'b0110);
        chk("R6", "no wait", item_req_o, 1);
        next_ptr_i = 32'h0;
        items(2, 0);
        chk("R7", "mixed end", ch_active_o, 0);
        clr(3'b111);

        // R9 peripheral flow control
        mode(0, 0, 0, 0);
        cfg_dmac_fc_i = 0;
        cfg_block_ts_i = 0;
        pulse_start();
        chk("R9", "zero length legal", ch_active_o, 1);
        chk("R9", "no err", err_irq_o, 0);
        items(5, 0);
        chk("R9", "runs on", ch_active_o, 1);
        items(1, 1);
        chk("R9", "last ends", ch_active_o, 0);
        chk("R9", "xfer", xfer_irq_o, 1);
        clr(3'b111);
        cfg_block_ts_i = 3;
        pulse_start();
        items(4, 0);
        chk("R9", "length ignored", ch_active_o, 1);
        items(1, 1);
        chk("R9", "last ends", ch_active_o, 0);
        clr(3'b111);
        cfg_dmac_fc_i = 1;

        // R10 zero length error
        cfg_block_ts_i = 0;
        pulse_start();
        chk("R10", "stays idle", ch_active_o, 0);
        chk("R10", "err flag", err_irq_o, 1);
        clr(3'b100);
        chk("R12", "err cleared", err_irq_o, 0);
        irq_en_i = 3'b011;
        pulse_start();
        chk("R12", "err masked", err_irq_o, 0);
        irq_en_i = 3'b111;

        // R11 item while idle
        items(1, 0);
        chk("R11", "err on stray item", err_irq_o, 1);
        clr(3'b100);

        // R12 sticky and independent clear
        irq_en_i = 3'b001;
        cfg_block_ts_i = 2;
        pulse_start();
        items(2, 0);
        chk("R12", "blk set", blk_irq_o, 1);
        chk("R12", "xfer masked", xfer_irq_o, 0);
        repeat (5) cyc();
        chk("R12", "blk sticky", blk_irq_o, 1);
        clr(3'b010);
        chk("R12", "other clear no effect", blk_irq_o, 1);
        clr(3'b001);
        chk("R12", "own clear", blk_irq_o, 0);
        irq_en_i = 3'b111;

        // R13 suspend
        cfg_block_ts_i = 4;
        pulse_start();
        items(1, 0);
        suspend_i = 1'b1;
        cyc();
        chk("R13", "no req", item_req_o, 0);
        chk("R13", "inactive drained", ch_inactive_o, 1);
        item_busy_i = 1'b1;
        #1;
        chk("R13", "busy not inactive", ch_inactive_o, 0);
        items(1, 0);
        item_busy_i = 1'b0;
        suspend_i = 1'b0;
        cyc();
        chk("R13", "resumes", item_req_o, 1);
        items(2, 0);
        chk("R13", "in-flight counted", ch_active_o, 0);
        item_busy_i = 1'b1;
        #1;
        chk("R13", "idle inactive", ch_inactive_o, 1);
        item_busy_i = 1'b0;
        clr(3'b111);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule